// File: doc/BRIEF.md
# Seven-Level Interrupt Priority Controller

This block merges interrupt requests from up to seven sources, each fixed to one priority level from 1 (lowest) to 7 (highest). Sources raise and drop their requests with single-cycle set and clear pulses that carry a level number. The block keeps one pending bit per level and drives a registered 3-bit priority code to the processor. The code is the highest level that is still pending, or 0 when none is.

When the processor acknowledges a level, the block answers one cycle later. The answer is an autovector if a device is wired to that level, and a spurious response if none is. The level-to-device map is a parameter. By default, devices sit at level 7 (the non-maskable source), level 2 (input) and level 1 (output). Acknowledging the non-maskable level drops its pending request by itself.

A set raises the output only when it adds a new pending bit above the current level. Any clear makes the block search the resulting pending bits from the top level down.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While rst is high and on the first cycle after it, prio_lvl is 0 and ack_done is 0, and no level is pending.
- R2: A set pulse (set_vld=1, set_lvl=N, N in 1..7) marks level N pending. If N is above the current prio_lvl, prio_lvl becomes N one clock later.
- R3: A set for a level that is already pending, or for a level at or below the current prio_lvl, leaves prio_lvl unchanged. A cycle with no set, clear or acknowledge also leaves prio_lvl unchanged.
- R4: A clear pulse (clr_vld=1, clr_lvl=N) drops level N. prio_lvl then becomes the highest remaining pending level, or 0 if no level is pending.
- R5: A set and a clear for different levels in the same cycle both take effect. prio_lvl is computed from the resulting pending set.
- R6: A set and a clear for the same level in the same cycle leave that level pending.
- R7: An acknowledge (ack_vld=1, ack_lvl=N) gives ack_done=1 for exactly one cycle, one clock later. ack_autovec=1 in that cycle if bit N of the device map is 1 (default map 8'b1000_0110: levels 7, 2 and 1).
- R8: Acknowledging a level whose map bit is 0 (default: 0, 3, 4, 5, 6) gives ack_done=1 with ack_autovec=0, the spurious response.
- R9: Acknowledging level 7 drops level 7's pending request, unless a set for level 7 arrives in the same cycle. Acknowledging any other level leaves the pending levels unchanged.
- R10: A set or clear carrying level 0 has no effect on the pending levels or on prio_lvl.
- R11: prio_lvl and the acknowledge outputs are registered: they change on the clock edge that samples the request, never combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_vld | input | 1 | Set pulse |
| set_lvl | input | 3 | Level to mark pending |
| clr_vld | input | 1 | Clear pulse |
| clr_lvl | input | 3 | Level to drop |
| ack_vld | input | 1 | Interrupt-acknowledge cycle |
| ack_lvl | input | 3 | Level being acknowledged |
| prio_lvl | output | 3 | Highest pending level, 0 if none |
| ack_done | output | 1 | One-cycle acknowledge response strobe |
| ack_autovec | output | 1 | 1 = autovector, 0 = spurious, valid with ack_done |

## Verification
The assertions check on every cycle that prio_lvl names a pending level and that no pending level lies above it. They also check that sets and clears reach the pending bits a cycle later, that the non-maskable acknowledge drops its request, that quiet cycles hold the output, and that each acknowledge is answered exactly once. The pending set is not visible at the ports. So only the bench can show that the lower levels left behind are the right ones. It does this by reading prio_lvl through chains of clears, including the empty result, same-cycle set and clear on equal and on different levels, and level-0 pulses.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic {
    ACK_SPURIOUS = 1'b0,
    ACK_AUTOVEC  = 1'b1
  } ack_kind_e;
endpackage

// File: rtl/irq_prio_enc.sv
// Priority search: returns the index of the highest set bit above bit 0.
module irq_prio_enc #(
  parameter int LEVELS = 7,
  parameter int LVL_W  = 3
) (
  input  logic [LEVELS:0]  mask_i,
  output logic [LVL_W-1:0] lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int i = 1; i <= LEVELS; i++) begin
      if (mask_i[i]) lvl_o = LVL_W'(i);
    end
  end
endmodule

// File: rtl/irq_pend_mask.sv
// Pending-request register: one bit per level, bit 0 never used.
module irq_pend_mask #(
  parameter int LEVELS  = 7,
  parameter int LVL_W   = 3,
  parameter int NMI_LVL = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_vld,
  input  logic [LVL_W-1:0] set_lvl,
  input  logic             clr_vld,
  input  logic [LVL_W-1:0] clr_lvl,
  input  logic             nmi_clr,
  output logic [LEVELS:0]  mask_q,
  output logic [LEVELS:0]  mask_d,
  output logic             set_new,
  output logic             clr_hit
);
  logic [LEVELS:0] set_oh;
  logic [LEVELS:0] clr_oh;

  genvar g;
  generate
    for (g = 0; g <= LEVELS; g++) begin : g_dec
      if (g == 0) begin : g_zero
        assign set_oh[g] = 1'b0;
        assign clr_oh[g] = 1'b0;
      end else begin : g_lvl
        assign set_oh[g] = set_vld && (set_lvl == LVL_W'(g));
        assign clr_oh[g] = (clr_vld && (clr_lvl == LVL_W'(g))) ||
                           (nmi_clr && (g == NMI_LVL));
      end
    end
  endgenerate

  // set applied after clear: a same-level set wins
  assign mask_d  = (mask_q & ~clr_oh) | set_oh;
  assign set_new = |(set_oh & ~mask_q);
  assign clr_hit = |clr_oh;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end

  p_set_lands_r6: assert property (@(posedge clk) disable iff (rst)
    (set_vld && set_lvl != '0 && int'(set_lvl) <= LEVELS)
      |=> mask_q[$past(set_lvl)]);

  p_clear_lands_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_vld && clr_lvl != '0 && int'(clr_lvl) <= LEVELS &&
     !(set_vld && set_lvl == clr_lvl))
      |=> !mask_q[$past(clr_lvl)]);

  p_nmi_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (nmi_clr && !(set_vld && int'(set_lvl) == NMI_LVL))
      |=> !mask_q[NMI_LVL]);

  p_bit0_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !mask_q[0]);
endmodule

// File: rtl/irq_ack_resp.sv
// Acknowledge responder: autovector for mapped levels, spurious otherwise.
module irq_ack_resp
  import irq_prio_pkg::*;
#(
  parameter int              LEVELS  = 7,
  parameter int              LVL_W   = 3,
  parameter int              NMI_LVL = 7,
  parameter logic [LEVELS:0] DEV_MAP = 8'b1000_0110
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_vld,
  input  logic [LVL_W-1:0] ack_lvl,
  output logic             nmi_clr,
  output logic             done_q,
  output ack_kind_e        kind_q
);
  logic mapped;

  always_comb begin
    mapped = 1'b0;
    for (int i = 0; i <= LEVELS; i++) begin
      if (ack_lvl == LVL_W'(i)) mapped = DEV_MAP[i];
    end
  end

  assign nmi_clr = ack_vld && (ack_lvl == LVL_W'(NMI_LVL));

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      kind_q <= ACK_SPURIOUS;
    end else begin
      done_q <= ack_vld;
      kind_q <= (ack_vld && mapped) ? ACK_AUTOVEC : ACK_SPURIOUS;
    end
  end

  p_ack_answered_r7: assert property (@(posedge clk) disable iff (rst)
    ack_vld |=> done_q);

  p_no_extra_done_r7: assert property (@(posedge clk) disable iff (rst)
    !ack_vld |=> !done_q);

  p_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && int'(ack_lvl) <= LEVELS && !DEV_MAP[ack_lvl])
      |=> (kind_q == ACK_SPURIOUS));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int              LEVELS  = 7,
  parameter int              NMI_LVL = LEVELS,
  parameter logic [LEVELS:0] DEV_MAP = 8'b1000_0110,
  localparam int             LVL_W   = $clog2(LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_vld,
  input  logic [LVL_W-1:0] set_lvl,
  input  logic             clr_vld,
  input  logic [LVL_W-1:0] clr_lvl,
  input  logic             ack_vld,
  input  logic [LVL_W-1:0] ack_lvl,
  output logic [LVL_W-1:0] prio_lvl,
  output logic             ack_done,
  output logic             ack_autovec
);
  logic [LEVELS:0]  mask_q;
  logic [LEVELS:0]  mask_d;
  logic             set_new;
  logic             clr_hit;
  logic             nmi_clr;
  logic [LVL_W-1:0] rescan_lvl;
  logic [LVL_W-1:0] lvl_q;
  ack_kind_e        kind_q;

  irq_ack_resp #(
    .LEVELS(LEVELS), .LVL_W(LVL_W), .NMI_LVL(NMI_LVL), .DEV_MAP(DEV_MAP)
  ) u_ack (
    .clk(clk), .rst(rst), .ack_vld(ack_vld), .ack_lvl(ack_lvl),
    .nmi_clr(nmi_clr), .done_q(ack_done), .kind_q(kind_q)
  );

  irq_pend_mask #(
    .LEVELS(LEVELS), .LVL_W(LVL_W), .NMI_LVL(NMI_LVL)
  ) u_pend (
    .clk(clk), .rst(rst),
    .set_vld(set_vld), .set_lvl(set_lvl),
    .clr_vld(clr_vld), .clr_lvl(clr_lvl),
    .nmi_clr(nmi_clr),
    .mask_q(mask_q), .mask_d(mask_d),
    .set_new(set_new), .clr_hit(clr_hit)
  );

  irq_prio_enc #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_enc (
    .mask_i(mask_d), .lvl_o(rescan_lvl)
  );

  // any clear rescans; a set only raises when it is new and higher
  always_ff @(posedge clk) begin
    if (rst)                                 lvl_q <= '0;
    else if (clr_hit)                        lvl_q <= rescan_lvl;
    else if (set_new && (set_lvl > lvl_q))   lvl_q <= set_lvl;
  end

  assign prio_lvl    = lvl_q;
  assign ack_autovec = (kind_q == ACK_AUTOVEC);

  p_lvl_pending_r4: assert property (@(posedge clk) disable iff (rst)
    (lvl_q != '0) |-> mask_q[lvl_q]);

  p_none_above_r4: assert property (@(posedge clk) disable iff (rst)
    ((mask_q >> lvl_q) <= (LEVELS + 1)'(1)));

  p_quiet_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!set_vld && !clr_vld && !ack_vld) |=> $stable(prio_lvl));

  p_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (set_vld && set_lvl > prio_lvl && int'(set_lvl) <= LEVELS &&
     !clr_vld && !ack_vld) |=> (prio_lvl == $past(set_lvl)));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       set_vld = 1'b0, clr_vld = 1'b0, ack_vld = 1'b0;
  logic [2:0] set_lvl = '0, clr_lvl = '0, ack_lvl = '0;
  logic [2:0] prio_lvl;
  logic       ack_done, ack_autovec;

  int         total = 0;
  int         bad = 0;
  bit         finished = 1'b0;
  logic [7:0] model = '0;
  localparam logic [7:0] MAP = 8'b1000_0110;

  always #5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst),
    .set_vld(set_vld), .set_lvl(set_lvl),
    .clr_vld(clr_vld), .clr_lvl(clr_lvl),
    .ack_vld(ack_vld), .ack_lvl(ack_lvl),
    .prio_lvl(prio_lvl), .ack_done(ack_done), .ack_autovec(ack_autovec)
  );

  function automatic logic [2:0] top_of(input logic [7:0] m);
    logic [2:0] r = '0;
    for (int i = 1; i < 8; i++) if (m[i]) r = 3'(i);
    return r;
  endfunction

  function automatic logic [7:0] next_of(input logic [7:0] m,
      input logic sv, input logic [2:0] sl, input logic cv, input logic [2:0] cl,
      input logic av, input logic [2:0] al);
    logic [7:0] n = m;
    if (cv && cl != 0) n[cl] = 1'b0;
    if (av && al == 3'd7) n[7] = 1'b0;
    if (sv && sl != 0) n[sl] = 1'b1;
    return n;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, clock, check at the next negedge
  task automatic cyc(input string tag, input logic sv, input logic [2:0] sl,
      input logic cv, input logic [2:0] cl, input logic av, input logic [2:0] al);
    set_vld = sv; set_lvl = sl; clr_vld = cv; clr_lvl = cl;
    ack_vld = av; ack_lvl = al;
    @(posedge clk);
    model = next_of(model, sv, sl, cv, cl, av, al);
    @(negedge clk);
    check(tag, "prio_lvl", int'(prio_lvl), int'(top_of(model)));
    check(tag, "ack_done", int'(ack_done), int'(av));
    if (av) check(tag, "ack_autovec", int'(ack_autovec), int'(MAP[al]));
    set_vld = 0; clr_vld = 0; ack_vld = 0;
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1a2b);
    repeat (3) @(negedge clk);
    check("R1", "prio_lvl in reset", int'(prio_lvl), 0);
    check("R1", "ack_done in reset", int'(ack_done), 0);
    rst = 1'b0;
    model = '0;
    idle("R1");

    // R2: rising levels, output follows one clock later (R11)
    cyc("R2", 1, 3'd2, 0, 0, 0, 0);
    cyc("R2", 1, 3'd5, 0, 0, 0, 0);
    // R3: lower, equal-pending, quiet
    cyc("R3", 1, 3'd1, 0, 0, 0, 0);
    cyc("R3", 1, 3'd5, 0, 0, 0, 0);
    idle("R3");
    // R10: level-0 set and clear do nothing
    cyc("R10", 1, 3'd0, 1, 3'd0, 0, 0);
    // R4: clear chain down to empty
    cyc("R4", 0, 0, 1, 3'd5, 0, 0);
    cyc("R4", 0, 0, 1, 3'd1, 0, 0);
    cyc("R4", 0, 0, 1, 3'd2, 0, 0);
    check("R4", "empty prio_lvl", int'(prio_lvl), 0);
    // R5: set and clear on different levels
    cyc("R5", 1, 3'd6, 0, 0, 0, 0);
    cyc("R5", 1, 3'd3, 1, 3'd6, 0, 0);
    check("R5", "prio after swap", int'(prio_lvl), 3);
    // R6: same level set and clear keeps it
    cyc("R6", 1, 3'd4, 1, 3'd4, 0, 0);
    check("R6", "same-level kept", int'(prio_lvl), 4);
    // R7/R8: acknowledges
    cyc("R7", 0, 0, 0, 0, 1, 3'd2);
    cyc("R7", 0, 0, 0, 0, 1, 3'd1);
    cyc("R8", 0, 0, 0, 0, 1, 3'd4);
    cyc("R8", 0, 0, 0, 0, 1, 3'd0);
    idle("R7");
    // R9: NMI acknowledge drops level 7, re-armed by same-cycle set
    cyc("R9", 1, 3'd7, 0, 0, 0, 0);
    cyc("R9", 0, 0, 0, 0, 1, 3'd7);
    check("R9", "nmi dropped", int'(prio_lvl), 4);
    cyc("R9", 1, 3'd7, 0, 0, 0, 0);
    cyc("R9", 1, 3'd7, 0, 0, 1, 3'd7);
    check("R9", "nmi re-armed", int'(prio_lvl), 7);
    // R1: reset mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model = '0;
    check("R1", "prio after reset", int'(prio_lvl), 0);
    idle("R1");

    // random mix (R5 tag covers the combined behaviour)
    for (int k = 0; k < 2000; k++) begin
      cyc("R5", 1'($urandom % 3 == 0), 3'($urandom), 1'($urandom % 4 == 0),
          3'($urandom), 1'($urandom % 5 == 0), 3'($urandom));
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule